// File: doc/BRIEF.md
# Addressed SPI Register-Memory Slave

This block is the serial front end of a small 64-byte register and memory space. An SPI master (mode 0: data sampled on the SCK rise, changed on the SCK fall, MSB first) opens a frame by lowering chip select. It then sends an identification byte that selects the operation and names the device, and after that a memory address byte and the data bytes. The block checks the identification against its strap pins. It streams read data out of a combinational read port and collects written bytes into a one-page buffer. When chip select rises it plays the buffered bytes out to a write port and ends with a done strobe. The storage array and the timed non-volatile write engine sit outside the block. The engine reports its write-in-progress state back on an input, and a status poll returns that state.

All serial pins are treated as already synchronised to `clk_i`. SCK and CS edges are found by comparing each pin with its registered copy. Two special cases are handled in the block. The first is a selection flag at the top control location: it routes the DAC register pair to a stored initial value instead of the live value. The second is a set of commit rules that protect that pair, the configuration byte and the reserved control bytes.

Top module: `spi_regmem_slave`

## Requirements
- R1: Serial input bits are taken only on an SCK rise while `cs_ni` and `rdy_ni` are both low. A frame sent with `rdy_ni` high causes no write strobe and leaves `so_oe_o` low.
- R2: The first byte of a frame is the identification byte: bit 7 selects the function, bits 6..1 carry the device address, and bit 0 selects the direction (1 = read). Function bit 0 selects a memory read or write.
- R3: If identification bits 6..1 differ from the strap value (zero-extended to six bits), the frame is ignored: no write strobe, and `so_oe_o` stays low.
- R4: The second byte is the start address. A value above 3Fh ignores the frame.
- R5: A read drives its first data bit on the first SCK fall after the address byte's last bit is taken. Bytes go out MSB first from consecutive addresses, and the address wraps from 3Fh to 00h.
- R6: Write bytes land at consecutive offsets inside the 8-byte page of the start address. The offset wraps within the page, and a later byte for the same offset replaces the earlier one. Write strobes are issued only after CS rises, one per cycle, in ascending offset order.
- R7: A data byte that is incomplete when CS rises is dropped, and the complete bytes before it are still written.
- R8: An identification byte with function bit 1 and direction bit 1 is a status poll. Every following byte returns 0000000b followed by `wip_i`, with bit 0 holding `wip_i`. Function bit 1 with direction bit 0 ignores the frame.
- R9: Writing 80h to 3Fh sets the selection flag, writing 00h clears it, and any other value leaves it unchanged. Reading 3Fh returns the flag in bit 7 and zeros below it. While the flag is set, reads of 38h/39h assert `mem_rnv_o`, and writes to 38h/39h assert `mem_wnv_o`.
- R10: A write that contains exactly one of 38h and 39h is dropped as a whole. A write that contains 3Ch together with any other byte is also dropped as a whole.
- R11: Bytes aimed at the reserved locations 3Ah, 3Bh, 3Dh and 3Eh never produce a write strobe.
- R12: `wr_done_o` pulses for one cycle after the last strobe of a commit that carries an accepted byte. `wr_done_nv_o` is high with it when any strobe in that commit targeted non-volatile storage: 00h..37h, 3Ch, or 38h/39h while the flag is set.
- R13: `so_oe_o` is low after reset and whenever CS is high. It rises only while read or poll data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples SCK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| rdy_ni | input | 1 | Ready qualifier, active low |
| strap_i | input | N_STRAP | Device address straps |
| wip_i | input | 1 | Write-in-progress from the non-volatile engine |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` (low = high impedance) |
| mem_raddr_o | output | 6 | Read address |
| mem_rnv_o | output | 1 | Read selects the stored initial value of the DAC pair |
| mem_rdata_i | input | 8 | Read data, combinational from `mem_raddr_o` |
| mem_we_o | output | 1 | Write strobe |
| mem_waddr_o | output | 6 | Write address |
| mem_wdata_o | output | 8 | Write data |
| mem_wnv_o | output | 1 | Write targets non-volatile storage |
| wr_done_o | output | 1 | Commit finished |
| wr_done_nv_o | output | 1 | Finished commit included a non-volatile byte |

## Verification
The closest collision is chip select rising on the same clock as the SCK rise that carries the eighth bit of a data byte. Whether that byte is kept decides what the commit writes. The bench provokes it by driving both pins high on the same clock edge. It judges the result at the ports: no strobe and no done pulse appear, and a later read returns the old contents of the target location. A second overlap, a flag write and a DAC-pair access in nearby frames, is judged by which bank a later read of 38h selects.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADR_W    = 6;
  localparam int PAGE_W   = 3;
  localparam int OFS_W    = ADR_W - PAGE_W;
  localparam int PAGE_LEN = 1 << OFS_W;
  localparam int ID_ADR_W = 6;

  localparam logic [ADR_W-1:0]  A_DAC_HI = 6'h38;
  localparam logic [ADR_W-1:0]  A_CFG    = 6'h3C;
  localparam logic [ADR_W-1:0]  A_FLAG   = 6'h3F;
  localparam logic [PAGE_W-1:0] CTRL_PG  = A_FLAG[ADR_W-1:OFS_W];

  localparam int OFS_HI   = int'(A_DAC_HI) % PAGE_LEN;
  localparam int OFS_CFG  = int'(A_CFG) % PAGE_LEN;
  localparam int OFS_FLAG = int'(A_FLAG) % PAGE_LEN;

  // offsets 2,3,5,6 of the control page are reserved
  localparam logic [PAGE_LEN-1:0] RSV_MASK = 8'b0110_1100;
  localparam logic [BYTE_W-1:0]   FLAG_ON  = 8'h80;
  localparam logic [BYTE_W-1:0]   FLAG_OFF = 8'h00;

  typedef enum logic [2:0] {FS_ID, FS_ADR, FS_RD, FS_WR, FS_POLL, FS_IGN} fstate_e;
endpackage

// File: rtl/spi_slv_frame.sv
module spi_slv_frame
  import spi_slv_pkg::*;
#(
  parameter int N_STRAP = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               si_i,
  input  logic               rdy_ni,
  input  logic [N_STRAP-1:0] strap_i,
  input  logic               wip_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic [ADR_W-1:0]   ptr_o,
  output logic               byte_vld_o,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               commit_o,
  output logic               so_o,
  output logic               so_oe_o
);
  logic              sck_q, rd_q, so_q, oe_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] rx_nxt, tx_q, tx_src;
  logic [ADR_W-1:0]  ptr_q, ptr_wr_nxt;
  logic [ID_ADR_W-1:0] id_exp;
  fstate_e           st_q;
  logic              rise, fall, byte_done, shifting;

  assign rise      = ~cs_ni & ~rdy_ni & sck_i & ~sck_q;
  assign fall      = ~cs_ni & ~rdy_ni & ~sck_i & sck_q;
  assign rx_nxt    = {rx_q, si_i};
  assign byte_done = rise & (cnt_q == 3'd7);
  assign shifting  = (st_q == FS_RD) || (st_q == FS_POLL);
  assign tx_src    = (st_q == FS_POLL) ? {{(BYTE_W-1){1'b0}}, wip_i} : rd_data_i;
  assign ptr_wr_nxt = {ptr_q[ADR_W-1:OFS_W], ptr_q[OFS_W-1:0] + OFS_W'(1)};

  always_comb begin
    id_exp = '0;
    id_exp[N_STRAP-1:0] = strap_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0; st_q <= FS_ID; cnt_q <= '0; rx_q <= '0; tx_q <= '0;
      rd_q <= 1'b0; ptr_q <= '0; so_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      if (cs_ni) begin
        st_q <= FS_ID; cnt_q <= '0; so_q <= 1'b0; oe_q <= 1'b0;
      end else begin
        if (rise) begin
          rx_q  <= rx_nxt[BYTE_W-2:0];
          cnt_q <= cnt_q + 3'd1;
          if (byte_done) begin
            case (st_q)
              FS_ID: begin
                if (rx_nxt[ID_ADR_W:1] != id_exp) st_q <= FS_IGN;
                else if (rx_nxt[BYTE_W-1])        st_q <= rx_nxt[0] ? FS_POLL : FS_IGN;
                else begin rd_q <= rx_nxt[0]; st_q <= FS_ADR; end
              end
              FS_ADR: begin
                if (rx_nxt[BYTE_W-1:ADR_W] != '0) st_q <= FS_IGN;
                else begin
                  ptr_q <= rx_nxt[ADR_W-1:0];
                  st_q  <= rd_q ? FS_RD : FS_WR;
                end
              end
              FS_RD:   ptr_q <= ptr_q + ADR_W'(1);
              FS_WR:   ptr_q <= ptr_wr_nxt;
              default: ;
            endcase
          end
        end
        if (fall && shifting) begin
          oe_q <= 1'b1;
          if (cnt_q == 3'd0) begin
            so_q <= tx_src[BYTE_W-1];
            tx_q <= {tx_src[BYTE_W-2:0], 1'b0};
          end else begin
            so_q <= tx_q[BYTE_W-1];
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign ptr_o      = ptr_q;
  assign byte_vld_o = byte_done & (st_q == FS_WR);
  assign byte_o     = rx_nxt;
  assign commit_o   = cs_ni & (st_q == FS_WR);
  assign so_o       = so_q;
  assign so_oe_o    = oe_q;

  p_hold_rdy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && rdy_ni) |=> $stable(cnt_q));
  p_oe_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !so_oe_o);
  p_rd_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FS_RD && byte_done && ptr_q == A_FLAG) |=> ptr_q == '0);
  p_page_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> ptr_q[ADR_W-1:OFS_W] == $past(ptr_q[ADR_W-1:OFS_W]));
endmodule

// File: rtl/spi_slv_wbuf.sv
module spi_slv_wbuf
  import spi_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic              commit_i,
  input  logic              flag_i,
  output logic              mem_we_o,
  output logic [ADR_W-1:0]  mem_waddr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_wnv_o,
  output logic              flag_we_o,
  output logic              flag_d_o,
  output logic              done_o,
  output logic              done_nv_o
);
  logic [BYTE_W-1:0]   dat_q [PAGE_LEN];
  logic [PAGE_LEN-1:0] msk_q, fl_msk_q, keep;
  logic [PAGE_W-1:0]   pg_q;
  logic [OFS_W-1:0]    idx_q;
  logic busy_q, fl_flag_q, nv_acc_q, done_q, done_nv_q;
  logic ctrl, pair_bad, cfg_bad, cur, at_flag;

  for (genvar i = 0; i < PAGE_LEN; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dat_q[i] <= '0; msk_q[i] <= 1'b0;
      end else if (commit_i) begin
        msk_q[i] <= 1'b0;
      end else if (byte_vld_i && addr_i[OFS_W-1:0] == OFS_W'(i)) begin
        dat_q[i] <= byte_i; msk_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= '0;
    else if (byte_vld_i) pg_q <= addr_i[ADR_W-1:OFS_W];
  end

  always_comb begin
    ctrl     = (pg_q == CTRL_PG);
    pair_bad = msk_q[OFS_HI] ^ msk_q[OFS_HI+1];
    cfg_bad  = msk_q[OFS_CFG] && ((msk_q & ~(PAGE_LEN'(1) << OFS_CFG)) != '0);
    if (!ctrl)                   keep = msk_q;
    else if (pair_bad || cfg_bad) keep = '0;
    else                         keep = msk_q & ~RSV_MASK;
  end

  assign at_flag     = ctrl && (idx_q == OFS_W'(OFS_FLAG));
  assign cur         = busy_q & fl_msk_q[idx_q];
  assign mem_we_o    = cur & ~at_flag;
  assign mem_waddr_o = {pg_q, idx_q};
  assign mem_wdata_o = dat_q[idx_q];
  assign mem_wnv_o   = ~ctrl | (idx_q == OFS_W'(OFS_CFG)) | fl_flag_q;
  assign flag_we_o   = cur & at_flag & (dat_q[idx_q] == FLAG_ON || dat_q[idx_q] == FLAG_OFF);
  assign flag_d_o    = (dat_q[idx_q] == FLAG_ON);
  assign done_o      = done_q;
  assign done_nv_o   = done_nv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_msk_q <= '0; busy_q <= 1'b0; idx_q <= '0; fl_flag_q <= 1'b0;
      nv_acc_q <= 1'b0; done_q <= 1'b0; done_nv_q <= 1'b0;
    end else begin
      done_q <= busy_q && (idx_q == '1);
      done_nv_q <= nv_acc_q | (mem_we_o & mem_wnv_o);
      if (commit_i) begin
        fl_msk_q <= keep; busy_q <= |keep; idx_q <= '0;
        fl_flag_q <= flag_i; nv_acc_q <= 1'b0;
      end else if (busy_q) begin
        idx_q    <= idx_q + OFS_W'(1);
        nv_acc_q <= nv_acc_q | (mem_we_o & mem_wnv_o);
        if (idx_q == '1) busy_q <= 1'b0;
      end
    end
  end

  p_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_waddr_o == A_DAC_HI) |=> (mem_we_o && mem_waddr_o == A_DAC_HI + ADR_W'(1)));
  p_rsv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !(mem_waddr_o inside {6'h3A, 6'h3B, 6'h3D, 6'h3E}));
  p_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_q) && !busy_q));
  p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i |-> !busy_q);
endmodule

// File: rtl/spi_regmem_slave.sv
module spi_regmem_slave
  import spi_slv_pkg::*;
#(
  parameter int N_STRAP = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               si_i,
  input  logic               rdy_ni,
  input  logic [N_STRAP-1:0] strap_i,
  input  logic               wip_i,
  output logic               so_o,
  output logic               so_oe_o,
  output logic [ADR_W-1:0]   mem_raddr_o,
  output logic               mem_rnv_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i,
  output logic               mem_we_o,
  output logic [ADR_W-1:0]   mem_waddr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  output logic               mem_wnv_o,
  output logic               wr_done_o,
  output logic               wr_done_nv_o
);
  logic [ADR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_data, byte_d;
  logic byte_vld, commit, flag_q, flag_we, flag_d;

  assign mem_raddr_o = ptr;
  assign mem_rnv_o   = flag_q & (ptr[ADR_W-1:1] == A_DAC_HI[ADR_W-1:1]);
  assign rd_data     = (ptr == A_FLAG) ? {flag_q, {(BYTE_W-1){1'b0}}} : mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_we) flag_q <= flag_d;
  end

  spi_slv_frame #(.N_STRAP(N_STRAP)) u_frame (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i, .rdy_ni, .strap_i, .wip_i,
    .rd_data_i(rd_data), .ptr_o(ptr), .byte_vld_o(byte_vld), .byte_o(byte_d),
    .commit_o(commit), .so_o, .so_oe_o
  );

  spi_slv_wbuf u_wbuf (
    .clk_i, .rst_ni, .byte_vld_i(byte_vld), .byte_i(byte_d), .addr_i(ptr),
    .commit_i(commit), .flag_i(flag_q), .mem_we_o, .mem_waddr_o, .mem_wdata_o,
    .mem_wnv_o, .flag_we_o(flag_we), .flag_d_o(flag_d),
    .done_o(wr_done_o), .done_nv_o(wr_done_nv_o)
  );

  p_flag_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q != $past(flag_q)) |-> $past(flag_we));
endmodule

// File: tb/spi_regmem_slave_tb_top.sv
module spi_regmem_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, rdy_n = 1'b0, wip = 1'b0;
  logic [5:0] strap = 6'b101101;
  logic so, so_oe, rnv, we, wnv, done, done_nv;
  logic [5:0] raddr, waddr;
  logic [7:0] rdata, wdata;

  logic [7:0] mem_m [64];
  logic [7:0] nvi_m [2];
  logic [7:0] tx_b [24];
  logic [7:0] rx_b [24];
  bit oe_hi [24];
  bit oe_lo [24];
  int checks = 0, errs = 0, done_cnt = 0, we_cnt = 0;
  bit last_wnv = 0, last_dnv = 0;

  localparam logic [7:0] ID_WR = 8'h5A, ID_RD = 8'h5B, ID_POLL = 8'hDB;

  always #2 clk = ~clk;

  assign rdata = rnv ? nvi_m[raddr[0]] : mem_m[raddr];

  spi_regmem_slave #(.N_STRAP(6)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .rdy_ni(rdy_n),
    .strap_i(strap), .wip_i(wip), .so_o(so), .so_oe_o(so_oe), .mem_raddr_o(raddr),
    .mem_rnv_o(rnv), .mem_rdata_i(rdata), .mem_we_o(we), .mem_waddr_o(waddr),
    .mem_wdata_o(wdata), .mem_wnv_o(wnv), .wr_done_o(done), .wr_done_nv_o(done_nv)
  );

  always @(posedge clk) begin
    if (we) begin
      if (wnv && waddr[5:1] == 5'b11100) nvi_m[waddr[0]] = wdata;
      else mem_m[waddr] = wdata;
      we_cnt++; last_wnv = wnv;
    end
    if (done) begin done_cnt++; last_dnv = done_nv; end
  end

  function automatic logic [7:0] orig(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic xfer(input int nbits, input bit clash);
    for (int k = 0; k < 24; k++) begin oe_hi[k] = 0; oe_lo[k] = 0; rx_b[k] = 0; end
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      int by = b / 8;
      int bi = 7 - (b % 8);
      si = tx_b[by][bi];
      repeat (4) @(negedge clk);
      rx_b[by][bi] = so;
      if (so_oe) oe_hi[by] = 1; else oe_lo[by] = 1;
      sck = 1'b1;
      if (clash && b == nbits - 1) cs_n = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    tx_b[0] = ID_RD; tx_b[1] = a;
    for (int k = 2; k < 24; k++) tx_b[k] = 8'h00;
    xfer(8 * (2 + n), 0);
  endtask

  task automatic t_reset;
    chk("R13 reset oe", int'(so_oe), 0);
    chk("R12 reset we", int'(we), 0);
    chk("R12 reset done", int'(done), 0);
  endtask

  task automatic t_read_wrap;
    rd(8'h3F, 3);
    chk("R9 read flag clear", rx_b[2], 8'h00);
    chk("R5 wrap byte0", rx_b[3], orig(0));
    chk("R5 wrap byte1", rx_b[4], orig(1));
    chk("R13 oe low in header", int'(oe_hi[0] | oe_hi[1]), 0);
    chk("R13 oe high in data", int'(oe_lo[2] | oe_lo[3] | oe_lo[4]), 0);
  endtask

  task automatic t_write_basic;
    int d0 = done_cnt;
    tx_b[0] = ID_WR; tx_b[1] = 8'h05; tx_b[2] = 8'h11; tx_b[3] = 8'h22; tx_b[4] = 8'h33;
    xfer(40, 0);
    chk("R12 done pulse", done_cnt - d0, 1);
    chk("R12 done nv", int'(last_dnv), 1);
    chk("R12 strobe nv", int'(last_wnv), 1);
    rd(8'h05, 3);
    chk("R2 write/read 05", rx_b[2], 8'h11);
    chk("R6 write/read 06", rx_b[3], 8'h22);
    chk("R6 write/read 07", rx_b[4], 8'h33);
  endtask

  task automatic t_page_wrap;
    tx_b[0] = ID_WR; tx_b[1] = 8'h0E;
    for (int k = 0; k < 10; k++) tx_b[2 + k] = 8'hC0 + 8'(k);
    xfer(8 * 12, 0);
    rd(8'h08, 8);
    for (int k = 0; k < 6; k++) chk("R6 page wrap", rx_b[2 + k], 8'hC2 + 8'(k));
    chk("R6 overwrite 0E", rx_b[8], 8'hC8);
    chk("R6 overwrite 0F", rx_b[9], 8'hC9);
  endtask

  task automatic t_rdy;
    int w0 = we_cnt;
    rdy_n = 1'b1;
    tx_b[0] = ID_WR; tx_b[1] = 8'h10; tx_b[2] = 8'h99;
    xfer(24, 0);
    chk("R1 no strobe when not ready", we_cnt - w0, 0);
    rd(8'h10, 1);
    chk("R1 no drive when not ready", int'(oe_hi[2]), 0);
    rdy_n = 1'b0;
    rd(8'h10, 1);
    chk("R1 location intact", rx_b[2], orig(16));
  endtask

  task automatic t_mismatch;
    int w0 = we_cnt;
    tx_b[0] = 8'h5C; tx_b[1] = 8'h10; tx_b[2] = 8'h99;
    xfer(24, 0);
    chk("R3 mismatch no write", we_cnt - w0, 0);
    tx_b[0] = 8'h5D; tx_b[1] = 8'h10; tx_b[2] = 8'h00;
    xfer(24, 0);
    chk("R3 mismatch no drive", int'(oe_hi[2]), 0);
  endtask

  task automatic t_bad_addr;
    int w0 = we_cnt;
    tx_b[0] = ID_WR; tx_b[1] = 8'h50; tx_b[2] = 8'h99;
    xfer(24, 0);
    chk("R4 address above 3F", we_cnt - w0, 0);
  endtask

  task automatic t_poll;
    int w0 = we_cnt;
    wip = 1'b1;
    tx_b[0] = ID_POLL; tx_b[1] = 8'h00; tx_b[2] = 8'h00;
    xfer(24, 0);
    chk("R8 poll busy b0", rx_b[1], 8'h01);
    chk("R8 poll busy b1", rx_b[2], 8'h01);
    chk("R8 poll drives", int'(oe_lo[1]), 0);
    wip = 1'b0;
    xfer(16, 0);
    chk("R8 poll idle", rx_b[1], 8'h00);
    tx_b[0] = 8'hDA; tx_b[1] = 8'h20; tx_b[2] = 8'h44;
    xfer(24, 0);
    chk("R8 select-1 write ignored", we_cnt - w0, 0);
  endtask

  task automatic t_flag;
    tx_b[0] = ID_WR; tx_b[1] = 8'h3F; tx_b[2] = 8'h80;
    xfer(24, 0);
    chk("R12 flag-only not nv", int'(last_dnv), 0);
    rd(8'h3F, 1);
    chk("R9 flag set", rx_b[2], 8'h80);
    tx_b[0] = ID_WR; tx_b[1] = 8'h38; tx_b[2] = 8'hAB; tx_b[3] = 8'hC0;
    xfer(32, 0);
    chk("R9 pair to nv bank", int'(last_wnv), 1);
    chk("R9 live reg untouched", mem_m[8'h38], orig(8'h38));
    rd(8'h38, 2);
    chk("R9 read nv hi", rx_b[2], 8'hAB);
    chk("R9 read nv lo", rx_b[3], 8'hC0);
    tx_b[0] = ID_WR; tx_b[1] = 8'h3F; tx_b[2] = 8'h55;
    xfer(24, 0);
    rd(8'h3F, 1);
    chk("R9 other value no change", rx_b[2], 8'h80);
    tx_b[0] = ID_WR; tx_b[1] = 8'h3F; tx_b[2] = 8'h00;
    xfer(24, 0);
    rd(8'h38, 1);
    chk("R9 flag clear live read", rx_b[2], orig(8'h38));
  endtask

  task automatic t_rules;
    int d0 = done_cnt;
    tx_b[0] = ID_WR; tx_b[1] = 8'h38; tx_b[2] = 8'h12;
    xfer(24, 0);
    tx_b[0] = ID_WR; tx_b[1] = 8'h3C; tx_b[2] = 8'h34; tx_b[3] = 8'h00;
    xfer(32, 0);
    chk("R10 lone half / cfg with others dropped", done_cnt - d0, 0);
    rd(8'h38, 1);
    chk("R10 38 unchanged", rx_b[2], orig(8'h38));
    tx_b[0] = ID_WR; tx_b[1] = 8'h3C; tx_b[2] = 8'h84;
    xfer(24, 0);
    chk("R10 cfg alone done", done_cnt - d0, 1);
    chk("R12 cfg nv", int'(last_dnv), 1);
    rd(8'h3C, 1);
    chk("R10 cfg stored", rx_b[2], 8'h84);
  endtask

  task automatic t_reserved;
    int w0 = we_cnt;
    tx_b[0] = ID_WR; tx_b[1] = 8'h3A; tx_b[2] = 8'hEE; tx_b[3] = 8'hEE;
    xfer(32, 0);
    chk("R11 reserved no strobe", we_cnt - w0, 0);
    rd(8'h3A, 1);
    chk("R11 reserved intact", rx_b[2], orig(8'h3A));
  endtask

  task automatic t_partial;
    int w0 = we_cnt;
    tx_b[0] = ID_WR; tx_b[1] = 8'h12; tx_b[2] = 8'h66; tx_b[3] = 8'h77;
    xfer(8 * 3 + 5, 0);
    chk("R7 one strobe", we_cnt - w0, 1);
    rd(8'h12, 2);
    chk("R7 full byte kept", rx_b[2], 8'h66);
    chk("R7 partial dropped", rx_b[3], orig(8'h13));
  endtask

  task automatic t_clash;
    int w0 = we_cnt;
    int d0 = done_cnt;
    tx_b[0] = ID_WR; tx_b[1] = 8'h14; tx_b[2] = 8'h88;
    xfer(24, 1);
    chk("R7 clash no strobe", we_cnt - w0, 0);
    chk("R12 clash no done", done_cnt - d0, 0);
    rd(8'h14, 1);
    chk("R7 clash location intact", rx_b[2], orig(8'h14));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = orig(i);
    nvi_m[0] = 8'h00; nvi_m[1] = 8'h00;
    for (int k = 0; k < 24; k++) tx_b[k] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_read_wrap;
    t_write_basic;
    t_page_wrap;
    t_rdy;
    t_mismatch;
    t_bad_addr;
    t_poll;
    t_flag;
    t_rules;
    t_reserved;
    t_partial;
    t_clash;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule